// File: doc/BRIEF.md
# Iterative TEA Block Encryptor

This block encrypts a single 64-bit block under a 128-bit key with the Tiny Encryption Algorithm. Both halves advance once per clock, so a block needs one clock per round. A running sum grows by a fixed constant each round. Each half is updated from the other half, the sum and its own pair of key words.

A producer offers the block as two 32-bit words, word 0 holding the first half (y) and word 1 the second half (z), together with four key words. The block takes them when `in_valid` and `in_ready` are both high at a rising edge, and it stores all of them. The producer may change the buses after that edge.

When the last round is done, the ciphertext sits in the same word order on the output. It stays there, with `out_valid` high, until the consumer raises `out_ready`. Only one block is in flight at a time. Reset is synchronous and active high.

Top module: `tea_encryptor`

## Requirements
- R1: While reset is high, and at the first sample after reset falls, `in_ready` is 1 and `out_valid` is 0.
- R2: A block is accepted at a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle on, `in_ready` stays 0 until the edge where `out_valid` and `out_ready` are both 1, after which it is 1 again.
- R3: `out_valid` rises exactly ROUNDS rising edges after the accepting edge, where ROUNDS defaults to 32. It never rises earlier.
- R4: The round sum starts at 0 for each block. It grows by DELTA (default 0x9E3779B9) at the start of every round, before either half changes, so after one round y is DELTA when data and key are all zero.
- R5: Each round adds `((z<<4)+key0) ^ (z+sum) ^ ((z>>5)+key1)` to y, modulo 2^32. The right shift fills with zeros, and y does not depend on key2 or key3.
- R6: In the same round, after y is updated, `((y<<4)+key2) ^ (y+sum) ^ ((y>>5)+key3)` is added to z, using the new y.
- R7: `in_word0` is y and `in_word1` is z. The ciphertext comes back with y on `out_word0` and z on `out_word1`.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` stays 1 and both output words hold their values.
- R9: Changes on the data and key inputs after the accepting edge do not change the result.
- R10: `in_valid` held high while a block is in progress is ignored. The result is that of the accepted block.
- R11: An all-zero key with all-zero data produces the same ciphertext as the round equations give.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Block and key offered |
| in_ready | output | 1 | Block can be accepted |
| in_word0 | input | 32 | Plaintext half y |
| in_word1 | input | 32 | Plaintext half z |
| key0 | input | 32 | Key word used in the y update |
| key1 | input | 32 | Key word used in the y update |
| key2 | input | 32 | Key word used in the z update |
| key3 | input | 32 | Key word used in the z update |
| out_valid | output | 1 | Ciphertext present |
| out_ready | input | 1 | Consumer takes ciphertext |
| out_word0 | output | 32 | Ciphertext half y |
| out_word1 | output | 32 | Ciphertext half z |

## Verification
The bench builds two copies of the block, both with DELTA 0x9E3779B9.

The first copy keeps ROUNDS at 32. It is compared with a reference model on zero, random and back-pressured traffic.

The second copy is built with ROUNDS set to 1, so a single round's output reaches the ports. This makes several properties directly observable:
- the sum starting value;
- the zero-filling right shift, driven with z's top bit set;
- the fact that y ignores key2 and key3.

// File: rtl/tea_pkg.sv
package tea_pkg;

  localparam int TEA_W = 32;

  typedef logic [TEA_W-1:0] tea_word_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } tea_state_e;

endpackage

// File: rtl/tea_round.sv
module tea_round
  import tea_pkg::*;
#(
  parameter tea_word_t DELTA = 32'h9E3779B9,
  parameter int        SHL   = 4,
  parameter int        SHR   = 5
) (
  input  tea_word_t y_i,
  input  tea_word_t z_i,
  input  tea_word_t sum_i,
  input  tea_word_t k0,
  input  tea_word_t k1,
  input  tea_word_t k2,
  input  tea_word_t k3,
  output tea_word_t y_o,
  output tea_word_t z_o,
  output tea_word_t sum_o
);

  tea_word_t sum_n;
  tea_word_t mix_y;
  tea_word_t y_n;
  tea_word_t mix_z;

  // sum advances first, then y from z, then z from the new y
  always_comb begin
    sum_n = sum_i + DELTA;
    mix_y = ((z_i << SHL) + k0) ^ (z_i + sum_n) ^ ((z_i >> SHR) + k1);
    y_n   = y_i + mix_y;
    mix_z = ((y_n << SHL) + k2) ^ (y_n + sum_n) ^ ((y_n >> SHR) + k3);
  end

  assign y_o   = y_n;
  assign z_o   = z_i + mix_z;
  assign sum_o = sum_n;

endmodule

// File: rtl/tea_ctrl.sv
module tea_ctrl
  import tea_pkg::*;
#(
  parameter int ROUNDS = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic out_ready,
  output logic load,
  output logic step,
  output logic in_ready,
  output logic out_valid
);

  localparam int               CNT_W = (ROUNDS > 1) ? $clog2(ROUNDS) : 1;
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(ROUNDS - 1);

  tea_state_e       st;
  logic [CNT_W-1:0] cnt;

  assign load      = (st == ST_IDLE) && in_valid;
  assign step      = (st == ST_RUN);
  assign in_ready  = (st == ST_IDLE);
  assign out_valid = (st == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= ST_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        ST_IDLE: begin
          cnt <= '0;
          if (in_valid) st <= ST_RUN;
        end
        ST_RUN: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST) st <= ST_DONE;
        end
        ST_DONE: begin
          if (out_ready) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tea_datapath.sv
module tea_datapath
  import tea_pkg::*;
#(
  parameter tea_word_t DELTA = 32'h9E3779B9,
  parameter int        SHL   = 4,
  parameter int        SHR   = 5,
  parameter int        NKEY  = 4
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      load,
  input  logic      step,
  input  tea_word_t in_y,
  input  tea_word_t in_z,
  input  tea_word_t key_in [NKEY],
  output tea_word_t y_q,
  output tea_word_t z_q
);

  tea_word_t sum_q;
  tea_word_t key_q [NKEY];
  tea_word_t y_d;
  tea_word_t z_d;
  tea_word_t sum_d;

  tea_round #(
    .DELTA (DELTA),
    .SHL   (SHL),
    .SHR   (SHR)
  ) u_round (
    .y_i   (y_q),
    .z_i   (z_q),
    .sum_i (sum_q),
    .k0    (key_q[0]),
    .k1    (key_q[1]),
    .k2    (key_q[2]),
    .k3    (key_q[3]),
    .y_o   (y_d),
    .z_o   (z_d),
    .sum_o (sum_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      y_q   <= '0;
      z_q   <= '0;
      sum_q <= '0;
    end else if (load) begin
      y_q   <= in_y;
      z_q   <= in_z;
      sum_q <= '0;
    end else if (step) begin
      y_q   <= y_d;
      z_q   <= z_d;
      sum_q <= sum_d;
    end
  end

  for (genvar g = 0; g < NKEY; g++) begin : g_key
    always_ff @(posedge clk) begin
      if (rst)       key_q[g] <= '0;
      else if (load) key_q[g] <= key_in[g];
    end
  end

endmodule

// File: rtl/tea_encryptor.sv
module tea_encryptor
  import tea_pkg::*;
#(
  parameter int        ROUNDS = 32,
  parameter tea_word_t DELTA  = 32'h9E3779B9,
  parameter int        SHL    = 4,
  parameter int        SHR    = 5
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_word0,
  input  logic [31:0] in_word1,
  input  logic [31:0] key0,
  input  logic [31:0] key1,
  input  logic [31:0] key2,
  input  logic [31:0] key3,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_word0,
  output logic [31:0] out_word1
);

  localparam int NKEY = 4;

  logic      load;
  logic      step;
  tea_word_t key_bus [NKEY];

  assign key_bus[0] = key0;
  assign key_bus[1] = key1;
  assign key_bus[2] = key2;
  assign key_bus[3] = key3;

  tea_ctrl #(
    .ROUNDS (ROUNDS)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .load      (load),
    .step      (step),
    .in_ready  (in_ready),
    .out_valid (out_valid)
  );

  tea_datapath #(
    .DELTA (DELTA),
    .SHL   (SHL),
    .SHR   (SHR),
    .NKEY  (NKEY)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .step   (step),
    .in_y   (in_word0),
    .in_z   (in_word1),
    .key_in (key_bus),
    .y_q    (out_word0),
    .z_q    (out_word1)
  );

endmodule

// File: rtl/tea_encryptor_chk.sv
module tea_encryptor_chk #(
  parameter int ROUNDS = 32
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_word0,
  input logic [31:0] out_word1
);

  logic        busy;
  logic [31:0] lat;

  // counts edges since the accepting edge
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      lat  <= '0;
    end else begin
      if (in_valid && in_ready) begin
        busy <= 1'b1;
        lat  <= '0;
      end else if (busy && !out_valid) begin
        lat <= lat + 1;
      end
      if (out_valid && out_ready) busy <= 1'b0;
    end
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (in_ready && !out_valid));

  p_busy_after_accept_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> !in_ready);

  p_ready_after_take_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> in_ready);

  p_not_both_r2: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

  p_exact_latency_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> (lat == 32'(ROUNDS)));

  p_not_early_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && lat < 32'(ROUNDS)) |-> !out_valid);

  p_hold_output_r8: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word0) && $stable(out_word1)));

endmodule

bind tea_encryptor tea_encryptor_chk #(.ROUNDS(ROUNDS)) u_tea_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_word0 (out_word0),
  .out_word1 (out_word1)
);

// File: tb/test_tea_encryptor.sv
module test_tea_encryptor;

  localparam logic [31:0] DELTA = 32'h9E3779B9;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic        in_valid  = 1'b0;
  logic        out_ready = 1'b0;
  logic        in_ready, out_valid;
  logic [31:0] d0 = '0, d1 = '0, k0 = '0, k1 = '0, k2 = '0, k3 = '0;
  logic [31:0] o0, o1;

  logic        in_valid1  = 1'b0;
  logic        out_ready1 = 1'b0;
  logic        in_ready1, out_valid1;
  logic [31:0] p0, p1;

  int total = 0;
  int bad   = 0;

  tea_encryptor i_tea_encryptor (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word0(d0), .in_word1(d1), .key0(k0), .key1(k1), .key2(k2), .key3(k3),
    .out_valid(out_valid), .out_ready(out_ready), .out_word0(o0), .out_word1(o1)
  );

  tea_encryptor #(.ROUNDS(1)) i_tea_encryptor_one (
    .clk(clk), .rst(rst), .in_valid(in_valid1), .in_ready(in_ready1),
    .in_word0(d0), .in_word1(d1), .key0(k0), .key1(k1), .key2(k2), .key3(k3),
    .out_valid(out_valid1), .out_ready(out_ready1), .out_word0(p0), .out_word1(p1)
  );

  function automatic logic [63:0] ref_enc(logic [31:0] y, logic [31:0] z,
                                          logic [31:0] a, logic [31:0] b,
                                          logic [31:0] c, logic [31:0] d, int n);
    logic [31:0] s;
    s = '0;
    for (int i = 0; i < n; i++) begin
      s = s + DELTA;
      y = y + ((((z << 4) + a) ^ (z + s)) ^ ((z >> 5) + b));
      z = z + ((((y << 4) + c) ^ (y + s)) ^ ((y >> 5) + d));
    end
    return {z, y};
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic send(logic [31:0] y, logic [31:0] z, logic [31:0] a,
                      logic [31:0] b, logic [31:0] c, logic [31:0] d);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    d0 = y; d1 = z; k0 = a; k1 = b; k2 = c; k3 = d;
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_out(output int lat);
    lat = 0;
    while (!out_valid) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic take(output logic [63:0] res);
    res = {o1, o0};
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic run_one(logic [31:0] y, logic [31:0] z, logic [31:0] a,
                         logic [31:0] b, logic [31:0] c, logic [31:0] d,
                         output logic [63:0] res);
    @(negedge clk);
    while (!in_ready1) @(negedge clk);
    d0 = y; d1 = z; k0 = a; k1 = b; k2 = c; k3 = d;
    in_valid1 = 1'b1;
    @(negedge clk);
    in_valid1 = 1'b0;
    while (!out_valid1) @(negedge clk);
    res = {p1, p0};
    out_ready1 = 1'b1;
    @(negedge clk);
    out_ready1 = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "in_ready/out_valid during reset", {62'd0, in_ready, out_valid}, 64'd2);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "in_ready/out_valid after reset", {62'd0, in_ready, out_valid}, 64'd2);
  endtask

  task automatic t_zero();
    logic [63:0] r;
    int lat;
    send('0, '0, '0, '0, '0, '0);
    chk("R2", "in_ready low after accept", {63'd0, in_ready}, 64'd0);
    wait_out(lat);
    chk("R3", "latency", 64'(lat), 64'd32);
    take(r);
    chk("R11", "all-zero ciphertext", r, ref_enc('0, '0, '0, '0, '0, '0, 32));
    chk("R2", "in_ready after take", {63'd0, in_ready}, 64'd1);
  endtask

  task automatic t_random();
    for (int v = 0; v < 6; v++) begin
      logic [31:0] y, z, a, b, c, d;
      logic [63:0] r, e;
      int lat;
      y = $urandom; z = $urandom; a = $urandom; b = $urandom; c = $urandom; d = $urandom;
      e = ref_enc(y, z, a, b, c, d, 32);
      send(y, z, a, b, c, d);
      wait_out(lat);
      take(r);
      chk("R3", "latency random", 64'(lat), 64'd32);
      chk("R7", "word0 is y", {32'd0, r[31:0]}, {32'd0, e[31:0]});
      chk("R6", "full ciphertext R5", r, e);
    end
  endtask

  task automatic t_backpressure();
    logic [63:0] r, held;
    int lat;
    send(32'h01234567, 32'h89ABCDEF, 32'h11111111, 32'h22222222, 32'h33333333, 32'h44444444);
    wait_out(lat);
    held = {o1, o0};
    repeat (12) @(negedge clk);
    chk("R8", "valid held", {62'd0, out_valid, in_ready}, 64'd2);
    chk("R8", "data held", {o1, o0}, held);
    take(r);
    chk("R8", "held result correct",
        r, ref_enc(32'h01234567, 32'h89ABCDEF, 32'h11111111, 32'h22222222,
                   32'h33333333, 32'h44444444, 32));
  endtask

  task automatic t_input_change();
    logic [63:0] r, e;
    int lat;
    e = ref_enc(32'hDEADBEEF, 32'hCAFEF00D, 32'h0F0F0F0F, 32'hF0F0F0F0,
                32'h12345678, 32'h9ABCDEF0, 32);
    send(32'hDEADBEEF, 32'hCAFEF00D, 32'h0F0F0F0F, 32'hF0F0F0F0, 32'h12345678, 32'h9ABCDEF0);
    d0 = $urandom; d1 = $urandom; k0 = $urandom; k1 = $urandom; k2 = $urandom; k3 = $urandom;
    wait_out(lat);
    take(r);
    chk("R9", "inputs changed after accept", r, e);
  endtask

  task automatic t_busy_ignore();
    logic [63:0] r, e;
    int lat;
    e = ref_enc(32'hA5A5A5A5, 32'h5A5A5A5A, 32'h1, 32'h2, 32'h3, 32'h4, 32);
    send(32'hA5A5A5A5, 32'h5A5A5A5A, 32'h1, 32'h2, 32'h3, 32'h4);
    d0 = 32'h77777777; d1 = 32'h88888888;
    in_valid = 1'b1;
    repeat (10) @(negedge clk);
    chk("R10", "in_ready low while busy", {63'd0, in_ready}, 64'd0);
    in_valid = 1'b0;
    wait_out(lat);
    chk("R3", "latency with in_valid held", 64'(lat), 64'd22);
    take(r);
    chk("R10", "result of accepted block", r, e);
  endtask

  task automatic t_one_round();
    logic [63:0] r, r2;
    run_one('0, '0, '0, '0, '0, '0, r);
    chk("R4", "one round y equals DELTA", {32'd0, r[31:0]}, {32'd0, DELTA});
    run_one(32'h00000001, 32'h80000000, 32'h10, 32'h20, 32'h30, 32'h40, r);
    chk("R5", "one round, z msb set", r,
        ref_enc(32'h00000001, 32'h80000000, 32'h10, 32'h20, 32'h30, 32'h40, 1));
    run_one(32'h00000001, 32'h80000000, 32'h10, 32'h20, 32'hFFFF0000, 32'h0000FFFF, r2);
    chk("R5", "y ignores key2/key3", {32'd0, r2[31:0]}, {32'd0, r[31:0]});
    chk("R6", "z uses new y and key2/key3", r2,
        ref_enc(32'h00000001, 32'h80000000, 32'h10, 32'h20, 32'hFFFF0000, 32'h0000FFFF, 1));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_zero();
    t_random();
    t_backpressure();
    t_input_change();
    t_busy_ignore();
    t_one_round();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule